// File: doc/BRIEF.md
# Three-Channel Prescaled Down-Count Timer

This peripheral holds three identical 32-bit down-counters behind a small synchronous register bus. Each channel counts down once per prescaled tick of the block clock. When a channel counts down past zero it copies its reload value back into the counter and raises a sticky underflow flag. Because the reload happens in hardware, the same channel works as a periodic tick source (reload holds the period) or as a one-shot delay (reload holds all ones, so the next underflow is far away).

Software starts and stops channels through one shared run register, with one bit per channel. It picks a clock divisor per channel, enables the channel's interrupt line, and clears the flag by writing its control register. The bus is word addressed on byte offsets, uses per-byte write strobes, and returns read data combinationally from the addressed register.

Top module: `dcnt_timer`

## Requirements
- R1: After reset the run register reads 0, every reload and counter register reads 0xFFFFFFFF, every control register reads 0, and all interrupt outputs are low.
- R2: The run register is at byte offset 0x00 and is written through byte 0. Bit n = 1 makes channel n count and 0 holds it. Changing one bit leaves the other channels counting or holding as before. Bits at and above the channel count read as 0.
- R3: Channel n's registers are at 0x04+12n (reload), 0x08+12n (counter) and 0x0C+12n (control). Reads of unmapped offsets return 0. Address bits [1:0] are ignored.
- R4: Control bits [2:0] select the divisor: code 0 gives 4, code 1 gives 16, code 2 gives 64, code 3 gives 256, code 4 gives 1024, and codes 5, 6 and 7 give 1024. The divisor counter is cleared while the channel is held, so the first decrement lands exactly one divisor period of clock edges after the edge that sets the run bit.
- R5: A running channel decrements its counter by one on each prescaled tick. A held channel keeps its counter unchanged.
- R6: A tick that finds the counter at 0 loads the reload value into the counter and sets the underflow flag, which is control bit 8.
- R7: A control write whose byte 1 is strobed with bit 8 = 0 clears the flag. Writing bit 8 = 1 leaves the flag as it is. If an underflow happens in the same cycle as a clearing write, the flag ends up set.
- R8: Control bit 5 is the interrupt enable. Interrupt output n is high exactly while channel n's flag and enable are both 1.
- R9: Only the bytes selected by the write strobes change. A write with no strobes changes nothing.
- R10: If a bus write to a counter lands in the same cycle as that counter's underflow reload, the written value is kept, and the flag is still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all counting derives from it |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (6) | Byte offset of the accessed register |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_be | input | 4 | Byte write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NCH (3) | Per-channel interrupt, high while flag and enable are set |

## Verification
The bench measures the first decrement after a start for every divisor code, including the three codes above 4. A design that did not clear the divisor counter while a channel is held, or that mapped codes 5 to 7 to a shorter divisor, would show its first decrement one or more edges early. It places a counter write and a flag-clearing write exactly on an underflow edge. A design with the priorities reversed would either lose the written count or drop the flag. It also stops one channel while its neighbour runs, and walks partial byte-strobe writes. A design that rewrote whole words or disturbed the other run bits would show a corrupted register or a stalled neighbour.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

    localparam int DW       = 32;
    localparam int NBYTE    = DW / 8;
    localparam int CTRL_W   = 16;
    localparam int START_W  = 8;
    localparam int PSC_W    = 3;
    localparam int PDIV_W   = 10;
    localparam int BIT_IE   = 5;
    localparam int BIT_UF   = 8;

    typedef struct packed {
        logic [DW-1:0]    rld;
        logic [DW-1:0]    cnt;
        logic [PSC_W-1:0] psc;
        logic             ie;
        logic             uf;
    } chan_st_t;

    function automatic logic [DW-1:0] byte_merge(
        input logic [DW-1:0]    old_v,
        input logic [DW-1:0]    new_v,
        input logic [NBYTE-1:0] be
    );
        logic [DW-1:0] r;
        r = old_v;
        for (int b = 0; b < NBYTE; b++) begin
            if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return r;
    endfunction

    // terminal value of the divisor counter (divisor minus one)
    function automatic logic [PDIV_W-1:0] psc_limit(input logic [PSC_W-1:0] code);
        case (code)
            3'd0:    return PDIV_W'(3);
            3'd1:    return PDIV_W'(15);
            3'd2:    return PDIV_W'(63);
            3'd3:    return PDIV_W'(255);
            default: return PDIV_W'(1023);
        endcase
    endfunction

endpackage

// File: rtl/dcnt_prescaler.sv
module dcnt_prescaler
    import dcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] code,
    output logic             tick
);

    logic [PDIV_W-1:0] div_d, div_q;
    logic [PDIV_W-1:0] lim;

    always_comb begin
        lim   = psc_limit(code);
        // >= so that a switch to a shorter divisor never overshoots
        tick  = run && (div_q >= lim);
        div_d = div_q + PDIV_W'(1);
        if (!run || tick) div_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

endmodule

// File: rtl/dcnt_channel.sv
module dcnt_channel
    import dcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_rld,
    input  logic              wr_cnt,
    input  logic              wr_ctrl,
    input  logic [NBYTE-1:0]  be,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rld,
    output logic [DW-1:0]     cnt,
    output logic [CTRL_W-1:0] ctrl,
    output logic              uf,
    output logic              tick,
    output logic              irq
);

    chan_st_t st_d, st_q;
    logic     under;

    dcnt_prescaler u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .code (st_q.psc),
        .tick (tick)
    );

    always_comb begin
        st_d  = st_q;
        under = tick && (st_q.cnt == '0);

        if (tick) begin
            if (under) st_d.cnt = st_q.rld;
            else       st_d.cnt = st_q.cnt - DW'(1);
        end

        if (wr_rld) st_d.rld = byte_merge(st_q.rld, wdata, be);
        // bus write takes priority over the hardware reload
        if (wr_cnt) st_d.cnt = byte_merge(st_q.cnt, wdata, be);

        if (wr_ctrl) begin
            if (be[0]) begin
                st_d.psc = wdata[PSC_W-1:0];
                st_d.ie  = wdata[BIT_IE];
            end
            if (be[1] && !wdata[BIT_UF]) st_d.uf = 1'b0;
        end
        // a fresh underflow beats a clearing write
        if (under) st_d.uf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rld <= '1;
            st_q.cnt <= '1;
            st_q.psc <= '0;
            st_q.ie  <= 1'b0;
            st_q.uf  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl                = '0;
        ctrl[PSC_W-1:0]     = st_q.psc;
        ctrl[BIT_IE]        = st_q.ie;
        ctrl[BIT_UF]        = st_q.uf;
        rld                 = st_q.rld;
        cnt                 = st_q.cnt;
        uf                  = st_q.uf;
        irq                 = st_q.uf & st_q.ie;
    end

endmodule

// File: rtl/dcnt_regbus.sv
module dcnt_regbus
    import dcnt_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 6
) (
    input  logic [AW-1:0]               addr,
    input  logic                        we,
    input  logic [NBYTE-1:0]            be,
    input  logic [NCH-1:0]              start,
    input  logic [NCH-1:0][DW-1:0]      rld,
    input  logic [NCH-1:0][DW-1:0]      cnt,
    input  logic [NCH-1:0][CTRL_W-1:0]  ctrl,
    output logic                        wr_start,
    output logic [NCH-1:0]              wr_rld,
    output logic [NCH-1:0]              wr_cnt,
    output logic [NCH-1:0]              wr_ctrl,
    output logic [DW-1:0]               rdata
);

    localparam int WW = AW - 2;

    logic [WW-1:0] word;
    logic          unused_lsb;

    assign word       = addr[AW-1:2];
    assign unused_lsb = ^addr[1:0];
    assign wr_start   = we && be[0] && (word == '0);

    for (genvar n = 0; n < NCH; n++) begin : g_dec
        localparam logic [WW-1:0] W_RLD  = WW'(1 + 3*n);
        localparam logic [WW-1:0] W_CNT  = WW'(2 + 3*n);
        localparam logic [WW-1:0] W_CTRL = WW'(3 + 3*n);
        assign wr_rld[n]  = we && (word == W_RLD);
        assign wr_cnt[n]  = we && (word == W_CNT);
        assign wr_ctrl[n] = we && (word == W_CTRL);
    end

    always_comb begin
        rdata = '0;
        if (word == '0) rdata[NCH-1:0] = start;
        for (int i = 0; i < NCH; i++) begin
            if (word == WW'(1 + 3*i)) rdata = rld[i];
            if (word == WW'(2 + 3*i)) rdata = cnt[i];
            if (word == WW'(3 + 3*i)) rdata = {{(DW-CTRL_W){1'b0}}, ctrl[i]};
        end
    end

endmodule

// File: rtl/dcnt_timer.sv
module dcnt_timer
    import dcnt_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [3:0]       bus_be,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic [NCH-1:0]   irq
);

    logic [NCH-1:0]              start_d, start_q;
    logic                        wr_start;
    logic [NCH-1:0]              wr_rld, wr_cnt, wr_ctrl;
    logic [NCH-1:0][DW-1:0]      rld_w, cnt_w;
    logic [NCH-1:0][CTRL_W-1:0]  ctrl_w;
    logic [NCH-1:0]              uf_w, tick_w;

    dcnt_regbus #(.NCH(NCH), .AW(AW)) u_bus (
        .addr    (bus_addr),
        .we      (bus_we),
        .be      (bus_be),
        .start   (start_q),
        .rld     (rld_w),
        .cnt     (cnt_w),
        .ctrl    (ctrl_w),
        .wr_start(wr_start),
        .wr_rld  (wr_rld),
        .wr_cnt  (wr_cnt),
        .wr_ctrl (wr_ctrl),
        .rdata   (bus_rdata)
    );

    always_comb begin
        start_d = start_q;
        if (wr_start) start_d = bus_wdata[NCH-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= '0;
        else        start_q <= start_d;
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        dcnt_channel u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (start_q[n]),
            .wr_rld (wr_rld[n]),
            .wr_cnt (wr_cnt[n]),
            .wr_ctrl(wr_ctrl[n]),
            .be     (bus_be),
            .wdata  (bus_wdata),
            .rld    (rld_w[n]),
            .cnt    (cnt_w[n]),
            .ctrl   (ctrl_w[n]),
            .uf     (uf_w[n]),
            .tick   (tick_w[n]),
            .irq    (irq[n])
        );
    end

endmodule

// File: rtl/dcnt_timer_chk.sv
module dcnt_timer_chk
    import dcnt_pkg::*;
#(
    parameter int NCH = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0]         run,
    input logic [NCH-1:0]         tick,
    input logic [NCH-1:0]         wr_cnt,
    input logic [NCH-1:0]         wr_ctrl,
    input logic [NCH-1:0]         uf,
    input logic [NCH-1:0][DW-1:0] cnt,
    input logic [NCH-1:0][DW-1:0] rld
);

    for (genvar n = 0; n < NCH; n++) begin : g_a
        a_r4_tick_only_when_running: assert property (
            @(posedge clk) disable iff (!rst_n)
            tick[n] |-> run[n]);

        a_r5_hold_when_stopped: assert property (
            @(posedge clk) disable iff (!rst_n)
            (!run[n] && !wr_cnt[n]) |=> cnt[n] == $past(cnt[n]));

        a_r5_step_down: assert property (
            @(posedge clk) disable iff (!rst_n)
            (tick[n] && cnt[n] != '0 && !wr_cnt[n]) |=> cnt[n] == $past(cnt[n]) - DW'(1));

        a_r6_reload_on_wrap: assert property (
            @(posedge clk) disable iff (!rst_n)
            (tick[n] && cnt[n] == '0 && !wr_cnt[n]) |=> cnt[n] == $past(rld[n]));

        a_r6_flag_on_wrap: assert property (
            @(posedge clk) disable iff (!rst_n)
            (tick[n] && cnt[n] == '0) |=> uf[n]);

        a_r7_flag_sticky: assert property (
            @(posedge clk) disable iff (!rst_n)
            (uf[n] && !wr_ctrl[n]) |=> uf[n]);
    end

endmodule

bind dcnt_timer dcnt_timer_chk #(.NCH(NCH)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (start_q),
    .tick   (tick_w),
    .wr_cnt (wr_cnt),
    .wr_ctrl(wr_ctrl),
    .uf     (uf_w),
    .cnt    (cnt_w),
    .rld    (rld_w)
);

// File: tb/dcnt_timer_tb.sv
module dcnt_timer_tb_top;

    localparam int NCH = 3;
    localparam int AW  = 6;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [AW-1:0]   bus_addr;
    logic            bus_we;
    logic [3:0]      bus_be;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  irq;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    dcnt_timer #(.NCH(NCH), .AW(AW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_be   (bus_be),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        // R1 reset values
        '{1'b0, 6'h00, 4'h0, 32'h0, 32'h0000_0000, 4'd1},
        '{1'b0, 6'h04, 4'h0, 32'h0, 32'hFFFF_FFFF, 4'd1},
        '{1'b0, 6'h08, 4'h0, 32'h0, 32'hFFFF_FFFF, 4'd1},
        '{1'b0, 6'h0C, 4'h0, 32'h0, 32'h0000_0000, 4'd1},
        '{1'b0, 6'h10, 4'h0, 32'h0, 32'hFFFF_FFFF, 4'd1},
        '{1'b0, 6'h14, 4'h0, 32'h0, 32'hFFFF_FFFF, 4'd1},
        '{1'b0, 6'h18, 4'h0, 32'h0, 32'h0000_0000, 4'd1},
        '{1'b0, 6'h1C, 4'h0, 32'h0, 32'hFFFF_FFFF, 4'd1},
        '{1'b0, 6'h20, 4'h0, 32'h0, 32'hFFFF_FFFF, 4'd1},
        '{1'b0, 6'h24, 4'h0, 32'h0, 32'h0000_0000, 4'd1},
        // R3 unmapped offsets and full-word access
        '{1'b0, 6'h28, 4'h0, 32'h0, 32'h0000_0000, 4'd3},
        '{1'b0, 6'h3C, 4'h0, 32'h0, 32'h0000_0000, 4'd3},
        '{1'b1, 6'h04, 4'hF, 32'h1122_3344, 32'h0, 4'd3},
        '{1'b0, 6'h06, 4'h0, 32'h0, 32'h1122_3344, 4'd3},
        // R9 byte strobes
        '{1'b1, 6'h04, 4'h0, 32'h0, 32'h0, 4'd9},
        '{1'b0, 6'h04, 4'h0, 32'h0, 32'h1122_3344, 4'd9},
        '{1'b1, 6'h10, 4'h5, 32'hAABB_CCDD, 32'h0, 4'd9},
        '{1'b0, 6'h10, 4'h0, 32'h0, 32'hFFBB_FFDD, 4'd9},
        '{1'b1, 6'h20, 4'hC, 32'h1234_5678, 32'h0, 4'd9},
        '{1'b0, 6'h20, 4'h0, 32'h0, 32'h1234_FFFF, 4'd9},
        // R7 writing bit 8 = 1 does not set the flag
        '{1'b1, 6'h24, 4'h3, 32'hFFFF_FFFF, 32'h0, 4'd7},
        '{1'b0, 6'h24, 4'h0, 32'h0, 32'h0000_0027, 4'd7},
        '{1'b1, 6'h24, 4'h3, 32'h0, 32'h0, 4'd7},
        '{1'b0, 6'h24, 4'h0, 32'h0, 32'h0000_0000, 4'd7},
        '{1'b1, 6'h18, 4'h3, 32'h0000_0003, 32'h0, 4'd4},
        '{1'b0, 6'h18, 4'h0, 32'h0, 32'h0000_0003, 4'd4},
        // R2 unused run bits read zero
        '{1'b1, 6'h00, 4'h1, 32'h0000_00FF, 32'h0, 4'd2},
        '{1'b0, 6'h00, 4'h0, 32'h0, 32'h0000_0007, 4'd2},
        '{1'b1, 6'h00, 4'h1, 32'h0000_0000, 32'h0, 4'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_addr  = a;
        bus_be    = be;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
        bus_be    = 4'h0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_we   = 1'b0;
        #2;
        d = bus_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] v;
        int          div;
        rst_n     = 1'b0;
        bus_addr  = '0;
        bus_we    = 1'b0;
        bus_be    = 4'h0;
        bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq", {29'd0, irq}, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                wr(VEC[i].addr, VEC[i].be, VEC[i].data);
            end else begin
                rd(VEC[i].addr, v);
                check($sformatf("R%0d vec%0d", VEC[i].req, i), v, VEC[i].exp);
            end
        end
        check("R8 irq after table", {29'd0, irq}, 32'h0);

        // R4: first decrement one full divisor period after start, per code
        for (int c = 0; c < 8; c++) begin
            div = (c > 4) ? 1024 : (4 << (2 * c));
            wr(6'h00, 4'h1, 32'h0);
            wr(6'h08, 4'hF, 32'd10);
            wr(6'h0C, 4'h3, c);
            wr(6'h00, 4'h1, 32'h1);
            repeat (div - 1) @(negedge clk);
            expect_reg($sformatf("R4 code%0d before", c), 6'h08, 32'd10);
            @(negedge clk);
            expect_reg($sformatf("R4 code%0d at", c), 6'h08, 32'd9);
        end

        // R6 / R8 underflow and interrupt, channel 0, divisor 4
        wr(6'h00, 4'h1, 32'h0);
        wr(6'h0C, 4'h3, 32'h0000_0020);
        wr(6'h04, 4'hF, 32'd2);
        wr(6'h08, 4'hF, 32'd1);
        wr(6'h00, 4'h1, 32'h1);
        repeat (7) @(negedge clk);
        expect_reg("R5 reached zero", 6'h08, 32'd0);
        expect_reg("R6 flag not yet", 6'h0C, 32'h0000_0020);
        check("R8 irq low before wrap", {31'd0, irq[0]}, 32'd0);
        @(negedge clk);
        expect_reg("R6 reload on wrap", 6'h08, 32'd2);
        expect_reg("R6 flag set", 6'h0C, 32'h0000_0120);
        check("R8 irq high", {31'd0, irq[0]}, 32'd1);
        repeat (4) @(negedge clk);
        expect_reg("R5 periodic step", 6'h08, 32'd1);
        wr(6'h00, 4'h1, 32'h0);
        repeat (20) @(negedge clk);
        expect_reg("R5 held when stopped", 6'h08, 32'd1);
        expect_reg("R7 flag sticky", 6'h0C, 32'h0000_0120);
        wr(6'h0C, 4'h3, 32'h0000_0100);
        expect_reg("R8 enable off keeps flag", 6'h0C, 32'h0000_0100);
        check("R8 irq masked", {31'd0, irq[0]}, 32'd0);
        wr(6'h0C, 4'h3, 32'h0000_0120);
        check("R8 irq re-enabled", {31'd0, irq[0]}, 32'd1);
        wr(6'h0C, 4'h3, 32'h0000_0020);
        expect_reg("R7 flag cleared", 6'h0C, 32'h0000_0020);
        check("R8 irq after clear", {31'd0, irq[0]}, 32'd0);

        // R10: counter write on the wrap edge
        wr(6'h04, 4'hF, 32'd7);
        wr(6'h08, 4'hF, 32'd0);
        wr(6'h00, 4'h1, 32'h1);
        repeat (3) @(negedge clk);
        wr(6'h08, 4'hF, 32'h55);
        wr(6'h00, 4'h1, 32'h0);
        expect_reg("R10 bus write wins", 6'h08, 32'h55);
        expect_reg("R10 flag still set", 6'h0C, 32'h0000_0120);

        // R7: clearing write on the wrap edge loses to the set
        wr(6'h0C, 4'h3, 32'h0000_0020);
        wr(6'h08, 4'hF, 32'd0);
        wr(6'h00, 4'h1, 32'h1);
        repeat (3) @(negedge clk);
        wr(6'h0C, 4'h3, 32'h0000_0020);
        wr(6'h00, 4'h1, 32'h0);
        expect_reg("R7 set beats clear", 6'h0C, 32'h0000_0120);
        expect_reg("R6 reloaded", 6'h08, 32'd7);

        // R2: stopping channel 0 leaves channel 1 counting
        wr(6'h0C, 4'h3, 32'h0);
        wr(6'h18, 4'h3, 32'h0);
        wr(6'h08, 4'hF, 32'd100);
        wr(6'h14, 4'hF, 32'd100);
        wr(6'h00, 4'h1, 32'h3);
        repeat (40) @(negedge clk);
        expect_reg("R2 ch0 running", 6'h08, 32'd90);
        expect_reg("R2 ch1 running", 6'h14, 32'd90);
        wr(6'h00, 4'h1, 32'h2);
        repeat (39) @(negedge clk);
        expect_reg("R2 ch0 halted", 6'h08, 32'd90);
        expect_reg("R2 ch1 unaffected", 6'h14, 32'd80);
        expect_reg("R2 ch2 never ran", 6'h20, 32'h1234_FFFF);
        check("R8 no irq", {29'd0, irq}, 32'h0);

        finish_run();
    end

endmodule